// File: doc/BRIEF.md
# Relock and Trusted-Time Supervisor

This block decides when the local timebase of a synchronized node may be trusted. It watches four qualification inputs: the link status, a frequency-lock indication from the servo, a flag saying the calibration coefficients have been loaded, and a flag saying the measurement window has stabilised. From these it steps a state machine through acquisition, relock and a settling period, and only then raises a trusted-time flag. On loss of link or frequency lock after time was trusted, it falls into holdover and keeps running on the local clock until the whole qualification sequence has been repeated.

A link must stay up for a programmable number of cycles before relock starts. The holdover indication is sticky across link bounces until trust is regained, so a flapping link cannot make the node alternate between holdover and lock. Every lock change, every link drop and every coefficient load produces a one-cycle event record stamped with a free-running cycle count, for a log interface downstream. The debounce and settle windows are set in clock cycles.

Top module: `trust_supervisor`

## Requirements
- R1: During and right after reset, `state_o` is 0 (FREERUN), `trusted_o`, `holdover_o` and `evt_valid_o` are 0.
- R2: State codes are FREERUN=0, HOLDOVER=1, LINK_UP=2, MEAS_READY=3, COEF_APPLIED=4, SETTLING=5, TRUSTED=6. From FREERUN or HOLDOVER, LINK_UP is entered at the clock edge where `link_up_i` has been sampled high on `cfg_debounce_i` consecutive edges (at least one); a low sample restarts the count.
- R3: The relock sequence is fixed: LINK_UP moves to MEAS_READY when frequency lock and measurement stability are both high; MEAS_READY moves to COEF_APPLIED when coefficients are loaded; COEF_APPLIED moves to SETTLING on the next edge while all four inputs are high.
- R4: SETTLING lasts `cfg_settle_i` cycles (at least one) with all inputs high, then TRUSTED is entered; `trusted_o` is high exactly while the state is TRUSTED.
- R5: In any state from LINK_UP on, a low link sample (and, from MEAS_READY on, a low frequency-lock sample) leaves the relock path on the next edge and `trusted_o` drops on that edge.
- R6: The fallback state is HOLDOVER only if TRUSTED has been reached since reset; otherwise it is FREERUN.
- R7: `holdover_o` rises on entry to HOLDOVER, stays high through any link bounce and through the relock states, and falls only on entry to TRUSTED.
- R8: A partial loss steps back rather than out: measurement stability low in MEAS_READY, COEF_APPLIED or SETTLING returns to LINK_UP; coefficients low in COEF_APPLIED or SETTLING returns to MEAS_READY; any of the four inputs low in TRUSTED enters HOLDOVER.
- R9: `evt_valid_o` pulses for one cycle on the edge where the cause is sampled, with `evt_code_o` 0 = trust gained, 1 = trust lost, 2 = link dropped (high to low), 3 = coefficients loaded (low to high), priority in that order, and `evt_time_o` equal to the number of edges since reset release before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | Link status |
| freq_lock_i | input | 1 | Frequency lock achieved by the servo |
| coef_done_i | input | 1 | Calibration coefficients loaded |
| meas_stable_i | input | 1 | Measurement window has stabilised |
| cfg_debounce_i | input | CNT_W | Link-up debounce length in cycles |
| cfg_settle_i | input | CNT_W | Post-relock settle length in cycles |
| state_o | output | 3 | Current state code |
| trusted_o | output | 1 | Local time may be trusted |
| holdover_o | output | 1 | Running on local clock after a loss of trust |
| evt_valid_o | output | 1 | Event record valid (one cycle) |
| evt_code_o | output | 2 | Event kind |
| evt_time_o | output | TS_W | Cycle stamp of the event |

## Verification
The assertions assume the two window lengths stay constant while a count is running, since the bounded-counter property compares the running count with the present limit; the stimulus sets both only while reset is held. They also assume reset is held for at least two edges so every past value they inspect is a reset value. The stimulus toggles link, lock, coefficient and stability inputs one step at a time in every relock state, including drops in the middle of debounce and settle, so each return path is taken with stable window settings.

// File: rtl/tts_pkg.sv
package tts_pkg;

    typedef enum logic [2:0] {
        ST_FREERUN      = 3'd0,
        ST_HOLDOVER     = 3'd1,
        ST_LINK_UP      = 3'd2,
        ST_MEAS_READY   = 3'd3,
        ST_COEF_APPLIED = 3'd4,
        ST_SETTLING     = 3'd5,
        ST_TRUSTED      = 3'd6
    } tts_state_e;

    typedef enum logic [1:0] {
        EV_TRUST_GAIN = 2'd0,
        EV_TRUST_LOSS = 2'd1,
        EV_LINK_DROP  = 2'd2,
        EV_COEF_LOAD  = 2'd3
    } tts_evt_e;

    typedef struct packed {
        logic link;
        logic lock;
        logic coef;
        logic meas;
    } tts_qual_s;

    function automatic logic is_acquiring(tts_state_e s);
        return (s == ST_FREERUN) || (s == ST_HOLDOVER);
    endfunction

    function automatic logic needs_lock(tts_state_e s);
        return (s == ST_MEAS_READY) || (s == ST_COEF_APPLIED) ||
               (s == ST_SETTLING)   || (s == ST_TRUSTED);
    endfunction

    function automatic logic all_good(tts_qual_s q);
        return q.link && q.lock && q.coef && q.meas;
    endfunction

endpackage

// File: rtl/tts_run_counter.sv
module tts_run_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign hit      = run && (cnt_next >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!hit) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (run && limit != '0) |-> (cnt < limit)); // R2

endmodule

// File: rtl/tts_fsm.sv
module tts_fsm
    import tts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tts_qual_s  qual,
    input  logic       dbc_hit,
    input  logic       settle_hit,
    output tts_state_e state,
    output logic       trusted,
    output logic       holdover,
    output logic       trust_gain,
    output logic       trust_loss
);
    tts_state_e nxt;
    tts_state_e fallback;
    logic       had_trusted;

    assign fallback = had_trusted ? ST_HOLDOVER : ST_FREERUN;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FREERUN, ST_HOLDOVER: begin
                if (dbc_hit) nxt = ST_LINK_UP;
            end
            ST_LINK_UP: begin
                if (!qual.link)                  nxt = fallback;
                else if (qual.lock && qual.meas) nxt = ST_MEAS_READY;
            end
            ST_MEAS_READY: begin
                if (!qual.link || !qual.lock) nxt = fallback;
                else if (!qual.meas)          nxt = ST_LINK_UP;
                else if (qual.coef)           nxt = ST_COEF_APPLIED;
            end
            ST_COEF_APPLIED: begin
                if (!qual.link || !qual.lock) nxt = fallback;
                else if (!qual.meas)          nxt = ST_LINK_UP;
                else if (!qual.coef)          nxt = ST_MEAS_READY;
                else                          nxt = ST_SETTLING;
            end
            ST_SETTLING: begin
                if (!qual.link || !qual.lock) nxt = fallback;
                else if (!qual.meas)          nxt = ST_LINK_UP;
                else if (!qual.coef)          nxt = ST_MEAS_READY;
                else if (settle_hit)          nxt = ST_TRUSTED;
            end
            ST_TRUSTED: begin
                if (!all_good(qual)) nxt = ST_HOLDOVER;
            end
            default: nxt = ST_FREERUN;
        endcase
    end

    assign trust_gain = (nxt == ST_TRUSTED) && (state != ST_TRUSTED);
    assign trust_loss = (state == ST_TRUSTED) && (nxt != ST_TRUSTED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_FREERUN;
            trusted     <= 1'b0;
            holdover    <= 1'b0;
            had_trusted <= 1'b0;
        end else begin
            state   <= nxt;
            trusted <= (nxt == ST_TRUSTED);
            if (nxt == ST_TRUSTED) begin
                had_trusted <= 1'b1;
                holdover    <= 1'b0;
            end else if (nxt == ST_HOLDOVER) begin
                holdover    <= 1'b1;
            end
        end
    end

    AST_TRUST_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        $rose(trusted) |-> ($past(state) == ST_SETTLING)); // R4

    AST_SETTLE_FROM_COEF: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLING && $past(state) != ST_SETTLING)
            |-> ($past(state) == ST_COEF_APPLIED)); // R3

    AST_LOCK_LOSS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (needs_lock(state) && !qual.lock)
            |=> (state == ST_FREERUN || state == ST_HOLDOVER)); // R5

endmodule

// File: rtl/tts_evt_log.sv
module tts_evt_log
    import tts_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            link,
    input  logic            coef,
    input  logic            trust_gain,
    input  logic            trust_loss,
    output logic            evt_valid,
    output tts_evt_e        evt_code,
    output logic [TS_W-1:0] evt_time
);
    logic            link_q;
    logic            coef_q;
    logic [TS_W-1:0] stamp;
    logic            link_drop;
    logic            coef_load;
    logic            any_evt;
    tts_evt_e        code_sel;

    assign link_drop = link_q && !link;
    assign coef_load = !coef_q && coef;
    assign any_evt   = trust_gain || trust_loss || link_drop || coef_load;

    always_comb begin
        if (trust_gain)      code_sel = EV_TRUST_GAIN;
        else if (trust_loss) code_sel = EV_TRUST_LOSS;
        else if (link_drop)  code_sel = EV_LINK_DROP;
        else                 code_sel = EV_COEF_LOAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q    <= 1'b0;
            coef_q    <= 1'b0;
            stamp     <= '0;
            evt_valid <= 1'b0;
            evt_code  <= EV_TRUST_GAIN;
            evt_time  <= '0;
        end else begin
            link_q    <= link;
            coef_q    <= coef;
            stamp     <= stamp + 1'b1;
            evt_valid <= any_evt;
            if (any_evt) begin
                evt_code <= code_sel;
                evt_time <= stamp;
            end
        end
    end

    AST_DROP_LOGGED: assert property (@(posedge clk) disable iff (rst)
        (link_q && !link) |=> evt_valid); // R9

endmodule

// File: rtl/trust_supervisor.sv
module trust_supervisor
    import tts_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up_i,
    input  logic             freq_lock_i,
    input  logic             coef_done_i,
    input  logic             meas_stable_i,
    input  logic [CNT_W-1:0] cfg_debounce_i,
    input  logic [CNT_W-1:0] cfg_settle_i,
    output logic [2:0]       state_o,
    output logic             trusted_o,
    output logic             holdover_o,
    output logic             evt_valid_o,
    output logic [1:0]       evt_code_o,
    output logic [TS_W-1:0]  evt_time_o
);
    tts_qual_s  qual;
    tts_state_e state;
    tts_evt_e   evt_code;
    logic       dbc_run;
    logic       dbc_hit;
    logic       settle_run;
    logic       settle_hit;
    logic       trust_gain;
    logic       trust_loss;

    assign qual = '{link: link_up_i, lock: freq_lock_i,
                    coef: coef_done_i, meas: meas_stable_i};

    assign dbc_run    = link_up_i && is_acquiring(state);
    assign settle_run = (state == ST_SETTLING);

    tts_run_counter #(.W(CNT_W)) u_debounce (
        .clk   (clk),
        .rst   (rst),
        .run   (dbc_run),
        .limit (cfg_debounce_i),
        .hit   (dbc_hit)
    );

    tts_run_counter #(.W(CNT_W)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .run   (settle_run),
        .limit (cfg_settle_i),
        .hit   (settle_hit)
    );

    tts_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .qual       (qual),
        .dbc_hit    (dbc_hit),
        .settle_hit (settle_hit),
        .state      (state),
        .trusted    (trusted_o),
        .holdover   (holdover_o),
        .trust_gain (trust_gain),
        .trust_loss (trust_loss)
    );

    tts_evt_log #(.TS_W(TS_W)) u_log (
        .clk        (clk),
        .rst        (rst),
        .link       (link_up_i),
        .coef       (coef_done_i),
        .trust_gain (trust_gain),
        .trust_loss (trust_loss),
        .evt_valid  (evt_valid_o),
        .evt_code   (evt_code),
        .evt_time   (evt_time_o)
    );

    assign state_o    = state;
    assign evt_code_o = evt_code;

    AST_LINKUP_DEBOUNCED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LINK_UP && is_acquiring($past(state)))
            |-> ($past(link_up_i) && $past(dbc_hit))); // R2

    AST_LINK_LOSS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!is_acquiring(state) && !link_up_i)
            |=> (is_acquiring(state) && !trusted_o)); // R5

    AST_HOLD_FROM_TRUST: assert property (@(posedge clk) disable iff (rst)
        $rose(holdover_o) |-> $past(trusted_o)); // R7

    AST_GAIN_LOGGED: assert property (@(posedge clk) disable iff (rst)
        $rose(trusted_o) |-> (evt_valid_o && evt_code_o == 2'd0)); // R9

    AST_LOSS_LOGGED: assert property (@(posedge clk) disable iff (rst)
        $fell(trusted_o) |-> (evt_valid_o && evt_code_o == 2'd1)); // R9

endmodule

// File: tb/trust_supervisor_tb.sv
module trust_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int TS_W       = 32;
    localparam int NVEC       = 38;

    // entry: {link,lock,coef,meas, state, trusted, holdover}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'b0000, 3'd0, 1'b0, 1'b0},  // 0  R1 idle
        {4'b1000, 3'd0, 1'b0, 1'b0},  // 1  R2 debounce 1 of 2
        {4'b0000, 3'd0, 1'b0, 1'b0},  // 2  R2 drop restarts
        {4'b1000, 3'd0, 1'b0, 1'b0},  // 3
        {4'b1000, 3'd2, 1'b0, 1'b0},  // 4  R2 LINK_UP
        {4'b1100, 3'd2, 1'b0, 1'b0},  // 5  R3 wait meas
        {4'b1101, 3'd3, 1'b0, 1'b0},  // 6  R3 MEAS_READY
        {4'b1111, 3'd4, 1'b0, 1'b0},  // 7  R3 COEF_APPLIED
        {4'b1111, 3'd5, 1'b0, 1'b0},  // 8  R3 SETTLING
        {4'b1111, 3'd5, 1'b0, 1'b0},  // 9  R4
        {4'b1111, 3'd5, 1'b0, 1'b0},  // 10 R4
        {4'b1111, 3'd6, 1'b1, 1'b0},  // 11 R4 TRUSTED
        {4'b1111, 3'd6, 1'b1, 1'b0},  // 12
        {4'b0111, 3'd1, 1'b0, 1'b1},  // 13 R5 link loss
        {4'b1111, 3'd1, 1'b0, 1'b1},  // 14 R7
        {4'b0111, 3'd1, 1'b0, 1'b1},  // 15 R7 flap
        {4'b1111, 3'd1, 1'b0, 1'b1},  // 16
        {4'b1111, 3'd2, 1'b0, 1'b1},  // 17 R7 holdover kept
        {4'b1111, 3'd3, 1'b0, 1'b1},  // 18
        {4'b1111, 3'd4, 1'b0, 1'b1},  // 19
        {4'b0111, 3'd1, 1'b0, 1'b1},  // 20 R6 back to HOLDOVER
        {4'b1111, 3'd1, 1'b0, 1'b1},  // 21
        {4'b1111, 3'd2, 1'b0, 1'b1},  // 22
        {4'b1111, 3'd3, 1'b0, 1'b1},  // 23
        {4'b1111, 3'd4, 1'b0, 1'b1},  // 24
        {4'b1111, 3'd5, 1'b0, 1'b1},  // 25
        {4'b1101, 3'd3, 1'b0, 1'b1},  // 26 R8 coef drop
        {4'b1111, 3'd4, 1'b0, 1'b1},  // 27
        {4'b1111, 3'd5, 1'b0, 1'b1},  // 28
        {4'b1111, 3'd5, 1'b0, 1'b1},  // 29
        {4'b1111, 3'd5, 1'b0, 1'b1},  // 30
        {4'b1111, 3'd6, 1'b1, 1'b0},  // 31 R7 holdover clears
        {4'b1011, 3'd1, 1'b0, 1'b1},  // 32 R5 lock loss
        {4'b1011, 3'd1, 1'b0, 1'b1},  // 33
        {4'b1011, 3'd2, 1'b0, 1'b1},  // 34
        {4'b1011, 3'd2, 1'b0, 1'b1},  // 35 R3 needs lock
        {4'b1111, 3'd3, 1'b0, 1'b1},  // 36
        {4'b1110, 3'd2, 1'b0, 1'b1}   // 37 R8 meas drop
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             link_up_i, freq_lock_i, coef_done_i, meas_stable_i;
    logic [CNT_W-1:0] cfg_debounce_i, cfg_settle_i;
    logic [2:0]       state_o;
    logic             trusted_o, holdover_o, evt_valid_o;
    logic [1:0]       evt_code_o;
    logic [TS_W-1:0]  evt_time_o;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    trust_supervisor #(.CNT_W(CNT_W), .TS_W(TS_W)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .link_up_i      (link_up_i),
        .freq_lock_i    (freq_lock_i),
        .coef_done_i    (coef_done_i),
        .meas_stable_i  (meas_stable_i),
        .cfg_debounce_i (cfg_debounce_i),
        .cfg_settle_i   (cfg_settle_i),
        .state_o        (state_o),
        .trusted_o      (trusted_o),
        .holdover_o     (holdover_o),
        .evt_valid_o    (evt_valid_o),
        .evt_code_o     (evt_code_o),
        .evt_time_o     (evt_time_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] lkcm);
        {link_up_i, freq_lock_i, coef_done_i, meas_stable_i} = lkcm;
    endtask

    task automatic do_reset(input int deb, input int stl);
        rst = 1'b1;
        drive(4'b0000);
        cfg_debounce_i = CNT_W'(deb);
        cfg_settle_i   = CNT_W'(stl);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset(2, 3);
        // R1 reset state, sampled with reset just released
        check("R1 state", 32'(state_o), 32'd0);
        check("R1 trusted/holdover/evt", {29'd0, trusted_o, holdover_o, evt_valid_o}, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][8:5]);
            @(negedge clk);
            check($sformatf("vector %0d (R2..R8)", i),
                  {27'd0, state_o, trusted_o, holdover_o}, {27'd0, VEC[i][4:0]});
        end

        // R6: fallback goes to FREERUN when never trusted
        do_reset(2, 3);
        drive(4'b1000);
        repeat (2) @(negedge clk);
        check("R2 link up after debounce", 32'(state_o), 32'd2);
        drive(4'b0000);
        @(negedge clk);
        check("R6 fallback freerun", {29'd0, state_o}, 32'd0);
        check("R6 no holdover", 32'(holdover_o), 32'd0);

        // R2: debounce of one cycle
        do_reset(1, 3);
        drive(4'b1000);
        @(negedge clk);
        check("R2 debounce=1", 32'(state_o), 32'd2);

        // R9 event records
        do_reset(2, 3);
        drive(4'b1111);
        @(negedge clk);
        check("R9 coef load valid", 32'(evt_valid_o), 32'd1);
        check("R9 coef load code", 32'(evt_code_o), 32'd3);
        check("R9 coef load time", evt_time_o, 32'(cyc - 1));
        @(negedge clk);
        check("R9 single-cycle pulse", 32'(evt_valid_o), 32'd0);
        repeat (5) @(negedge clk);
        check("R4 settling before trust", 32'(state_o), 32'd5);
        check("R4 not yet trusted", 32'(trusted_o), 32'd0);
        @(negedge clk);
        check("R4 trusted", 32'(trusted_o), 32'd1);
        check("R9 gain code", {29'd0, evt_valid_o, evt_code_o}, 32'b100);
        check("R9 gain time", evt_time_o, 32'(cyc - 1));
        drive(4'b0111);
        @(negedge clk);
        check("R5 trust dropped", 32'(trusted_o), 32'd0);
        check("R9 loss beats drop", {29'd0, evt_valid_o, evt_code_o}, 32'b101);
        drive(4'b1111);
        @(negedge clk);
        check("R9 no event on rise", 32'(evt_valid_o), 32'd0);
        drive(4'b0111);
        @(negedge clk);
        check("R9 drop code", {29'd0, evt_valid_o, evt_code_o}, 32'b110);
        check("R9 drop time", evt_time_o, 32'(cyc - 1));
        check("R7 holdover during flap", {29'd0, state_o}, 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule